// File: doc/BRIEF.md
# Sign-Magnitude Sample Packer with Ping-Pong Buffers

This block sits behind a radio front end that delivers one 2-bit quantized sample on every rising edge of the sample clock. Each sample has a sign bit and a magnitude bit. The block gathers sixteen consecutive samples into one 32-bit word. It then writes that word into one of two external FIFO buffers. The word rate is therefore one sixteenth of the sample rate.

Filling starts in buffer A. When the buffer being filled has taken its configured number of words, the block raises an interrupt that names the full buffer and moves filling to the other buffer. The host drains the full buffer while acquisition continues, then pulses a clear. If the host has still not cleared the pending interrupt when the second buffer also fills, a sticky overrun flag rises. Finished words are then discarded until the clear comes. Packing itself never pauses.

Top module: `smag_pingpong_packer`

## Requirements
- R1: A synchronous reset, held over at least one clock edge, drops both write enables, the interrupt and the overrun flag, selects buffer A for filling and discards any partly gathered word. The first sixteen samples after reset form the first word.
- R2: Inside a word, the first captured sample occupies bits [1:0], with the sign in bit 1 and the magnitude in bit 0. Sample k (counting from 0) occupies bits [2k+1:2k]. The word's write enable and data appear in the cycle after the edge that captures its sixteenth sample.
- R3: Each finished word is written to the buffer currently being filled, and at most one of the two write enables is high in any cycle. The write enable for a buffer is high for exactly one cycle per word.
- R4: When a buffer takes its DEPTH-th word, the interrupt goes high in the same cycle as that write. At that point irq_buf names that buffer (0 = A, 1 = B), and the following words go to the other buffer.
- R5: Once high, the interrupt stays high until irq_clr is sampled high. A clear with no overrun pending drops it in the next cycle.
- R6: If a buffer fills while the interrupt is still pending, the overrun flag is set in the same cycle as that last write and stays set. No write enable rises while it is set.
- R7: A clear sampled while the overrun flag is set drops that flag and keeps the interrupt high. irq_buf then names the buffer that filled during the overrun, and filling restarts at word 0 of the other buffer. Sample packing runs on through the overrun without losing word alignment.
- R8: While every interrupt is cleared in time, filling keeps alternating A, B, A, B, with DEPTH words in each buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample is captured on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_sign | input | 1 | Sign bit of the current sample |
| smp_mag | input | 1 | Magnitude bit of the current sample |
| irq_clr | input | 1 | Host clear pulse, one cycle |
| wr_a_en | output | 1 | Write strobe for buffer A |
| wr_a_data | output | WORD_W | Word for buffer A |
| wr_b_en | output | 1 | Write strobe for buffer B |
| wr_b_data | output | WORD_W | Word for buffer B |
| irq | output | 1 | A buffer is full and ready to drain |
| irq_buf | output | 1 | Buffer ready to drain: 0 = A, 1 = B |
| overrun | output | 1 | Sticky flag: a buffer filled while the interrupt was still pending |

## Verification
The assertions assume that irq_clr is a short pulse from a host. They also assume that a clear never lands on the same edge that completes a buffer's last word, because in that case the dropped interrupt and a new one would overlap in a single cycle. The bench keeps every clear well inside a word, at sample positions 1 to 5, so it is never near the sixteenth sample. It drives samples without a gap, so word boundaries follow directly from the sample count since reset.

// File: rtl/smag_pkg.sv
package smag_pkg;
  typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_sel_e;
endpackage

// File: rtl/smag_word_packer.sv
module smag_word_packer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_sign,
  input  logic              smp_mag,
  output logic              word_done,
  output logic [WORD_W-1:0] word_data
);
  localparam int SMP_PER_WORD = WORD_W / 2;
  localparam int IDX_W = (SMP_PER_WORD > 1) ? $clog2(SMP_PER_WORD) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SMP_PER_WORD - 1);

  // Holds the earlier samples of the word; the oldest sample sits lowest.
  logic [WORD_W-3:0] acc_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      idx_q <= '0;
    end else begin
      acc_q <= {smp_sign, smp_mag, acc_q[WORD_W-3:2]};
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign word_done = (idx_q == IDX_LAST);
  assign word_data = {smp_sign, smp_mag, acc_q};
endmodule

// File: rtl/smag_pingpong_ctrl.sv
module smag_pingpong_ctrl
  import smag_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     word_done,
  input  logic     irq_clr,
  output logic     wr_go,
  output buf_sel_e wr_sel,
  output logic     irq,
  output buf_sel_e irq_buf,
  output logic     overrun
);
  localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  buf_sel_e         cur_q, cur_n, rdy_q, rdy_n;
  logic             irq_q, irq_n, ovr_q, ovr_n;

  function automatic buf_sel_e other(input buf_sel_e b);
    return (b == BUF_A) ? BUF_B : BUF_A;
  endfunction

  always_comb begin
    cnt_n = cnt_q;
    cur_n = cur_q;
    rdy_n = rdy_q;
    irq_n = irq_q;
    ovr_n = ovr_q;
    wr_go = word_done && !ovr_q;
    if (irq_clr) begin
      if (ovr_q) begin
        // Host drained the pending buffer; report the one filled meanwhile.
        rdy_n = cur_q;
        cur_n = other(cur_q);
        cnt_n = '0;
        ovr_n = 1'b0;
      end else begin
        irq_n = 1'b0;
      end
    end
    if (wr_go) begin
      if (cnt_q == CNT_LAST) begin
        cnt_n = '0;
        if (!irq_n) begin
          irq_n = 1'b1;
          rdy_n = cur_q;
          cur_n = other(cur_q);
        end else begin
          ovr_n = 1'b1;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cur_q <= BUF_A;
      rdy_q <= BUF_A;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      cur_q <= cur_n;
      rdy_q <= rdy_n;
      irq_q <= irq_n;
      ovr_q <= ovr_n;
    end
  end

  assign wr_sel  = cur_q;
  assign irq     = irq_q;
  assign irq_buf = rdy_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/smag_pingpong_packer.sv
module smag_pingpong_packer
  import smag_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_sign,
  input  logic              smp_mag,
  input  logic              irq_clr,
  output logic              wr_a_en,
  output logic [WORD_W-1:0] wr_a_data,
  output logic              wr_b_en,
  output logic [WORD_W-1:0] wr_b_data,
  output logic              irq,
  output logic              irq_buf,
  output logic              overrun
);
  localparam int NBUF = 2;

  logic              word_done, wr_go;
  logic [WORD_W-1:0] word_data;
  buf_sel_e          wr_sel, rdy_buf;
  logic              en_q   [NBUF];
  logic [WORD_W-1:0] data_q [NBUF];

  smag_word_packer #(.WORD_W(WORD_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .smp_sign  (smp_sign),
    .smp_mag   (smp_mag),
    .word_done (word_done),
    .word_data (word_data)
  );

  smag_pingpong_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .irq_clr   (irq_clr),
    .wr_go     (wr_go),
    .wr_sel    (wr_sel),
    .irq       (irq),
    .irq_buf   (rdy_buf),
    .overrun   (overrun)
  );

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[gi]   <= 1'b0;
        data_q[gi] <= '0;
      end else begin
        en_q[gi] <= wr_go && (wr_sel == buf_sel_e'(gi));
        if (wr_go && (wr_sel == buf_sel_e'(gi))) data_q[gi] <= word_data;
      end
    end
  end

  assign wr_a_en   = en_q[0];
  assign wr_a_data = data_q[0];
  assign wr_b_en   = en_q[1];
  assign wr_b_data = data_q[1];
  assign irq_buf   = rdy_buf;
endmodule

// File: rtl/smag_pingpong_packer_chk.sv
module smag_pingpong_packer_chk (
  input logic clk,
  input logic rst,
  input logic irq_clr,
  input logic wr_a_en,
  input logic wr_b_en,
  input logic irq,
  input logic irq_buf,
  input logic overrun
);
  a_r3_one_port: assert property (@(posedge clk) disable iff (rst)
    !(wr_a_en && wr_b_en));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_a_en || wr_b_en) |=> !(wr_a_en || wr_b_en));

  a_r4_irq_with_write: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (irq_buf ? wr_b_en : wr_a_en));

  a_r5_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !irq_clr) |=> overrun);

  a_r6_ovr_needs_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> irq);

  a_r6_no_write: assert property (@(posedge clk) disable iff (rst)
    overrun |=> !(wr_a_en || wr_b_en));

  a_r7_resume: assert property (@(posedge clk) disable iff (rst)
    (overrun && irq_clr) |=> (irq && !overrun));
endmodule

bind smag_pingpong_packer smag_pingpong_packer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_clr (irq_clr),
  .wr_a_en (wr_a_en),
  .wr_b_en (wr_b_en),
  .irq     (irq),
  .irq_buf (irq_buf),
  .overrun (overrun)
);

// File: tb/smag_pingpong_packer_tb.sv
module smag_pingpong_packer_tb;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 4;
  localparam int NONE = -1, PA = 0, PB = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_sign = 1'b0, smp_mag = 1'b0, irq_clr = 1'b0;
  logic        wr_a_en, wr_b_en, irq, irq_buf, overrun;
  logic [31:0] wr_a_data, wr_b_data;
  int          checks = 0, fails = 0;

  smag_pingpong_packer #(.WORD_W(32), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .smp_sign(smp_sign), .smp_mag(smp_mag),
    .irq_clr(irq_clr), .wr_a_en(wr_a_en), .wr_a_data(wr_a_data),
    .wr_b_en(wr_b_en), .wr_b_data(wr_b_data), .irq(irq),
    .irq_buf(irq_buf), .overrun(overrun)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Drives sixteen samples of w (pair k = w[2k+1:2k]); pulses clear at sample
  // clr_at; checks the write that follows the sixteenth edge.
  task automatic feed_word(input logic [31:0] w, input int clr_at,
                           input int exp_port, input string req);
    int stray = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k > 0 && (wr_a_en || wr_b_en)) stray++;
      rst      = 1'b0;
      smp_sign = w[2*k+1];
      smp_mag  = w[2*k];
      irq_clr  = (k == clr_at);
    end
    @(posedge clk);
    #1;
    chk(stray == 0, "R3", "writes inside word", 32'(stray), 32'd0);
    chk(wr_a_en == (exp_port == PA), req, "wr_a_en", 32'(wr_a_en), 32'(exp_port == PA));
    chk(wr_b_en == (exp_port == PB), req, "wr_b_en", 32'(wr_b_en), 32'(exp_port == PB));
    if (exp_port == PA) chk(wr_a_data === w, "R2", "wr_a_data", wr_a_data, w);
    if (exp_port == PB) chk(wr_b_data === w, "R2", "wr_b_data", wr_b_data, w);
  endtask

  task automatic flags(input logic ei, input logic eb, input logic eo, input string req);
    chk(irq === ei, req, "irq", 32'(irq), 32'(ei));
    if (ei) chk(irq_buf === eb, req, "irq_buf", 32'(irq_buf), 32'(eb));
    chk(overrun === eo, req, "overrun", 32'(overrun), 32'(eo));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!wr_a_en && !wr_b_en, "R1", "write enables in reset", 32'({wr_a_en, wr_b_en}), 32'd0);
    flags(1'b0, 1'b0, 1'b0, "R1");
  endtask

  task automatic sc_pack();
    feed_word(32'h1B2D_4E87, NONE, PA, "R2");
    flags(1'b0, 1'b0, 1'b0, "R2");
    feed_word(32'hFFFF_0000, NONE, PA, "R2");
    feed_word(32'h8000_0001, NONE, PA, "R2");
  endtask

  task automatic sc_fill_a();
    feed_word(32'hA5A5_A5A5, NONE, PA, "R4");
    flags(1'b1, 1'b0, 1'b0, "R4");
  endtask

  task automatic sc_swap_b();
    feed_word(32'h5A5A_5A5A, NONE, PB, "R4");
    flags(1'b1, 1'b0, 1'b0, "R5");
    feed_word(32'h0123_4567, 3, PB, "R3");
    flags(1'b0, 1'b0, 1'b0, "R5");
    feed_word(32'h89AB_CDEF, NONE, PB, "R3");
    feed_word(32'hC3C3_3C3C, NONE, PB, "R4");
    flags(1'b1, 1'b1, 1'b0, "R4");
  endtask

  task automatic sc_back_a();
    feed_word(32'h1111_2222, 2, PA, "R8");
    flags(1'b0, 1'b0, 1'b0, "R8");
    feed_word(32'h3333_4444, NONE, PA, "R8");
    feed_word(32'h5555_6666, NONE, PA, "R8");
    feed_word(32'h7777_8888, NONE, PA, "R8");
    flags(1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic sc_overrun();
    feed_word(32'h9999_AAAA, NONE, PB, "R8");
    feed_word(32'hBBBB_CCCC, NONE, PB, "R8");
    feed_word(32'hDDDD_EEEE, NONE, PB, "R8");
    feed_word(32'hF0F0_0F0F, NONE, PB, "R6");
    flags(1'b1, 1'b0, 1'b1, "R6");
    feed_word(32'h1234_5678, NONE, NONE, "R6");
    feed_word(32'h8765_4321, NONE, NONE, "R6");
    flags(1'b1, 1'b0, 1'b1, "R6");
  endtask

  task automatic sc_resume();
    feed_word(32'hDEAD_BEEF, 4, PA, "R7");
    flags(1'b1, 1'b1, 1'b0, "R7");
    feed_word(32'hCAFE_F00D, 1, PA, "R7");
    flags(1'b0, 1'b0, 1'b0, "R5");
  endtask

  task automatic sc_midreset();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      smp_sign = 1'b1; smp_mag = 1'b1; irq_clr = 1'b0;
    end
    do_reset();
    feed_word(32'h2468_ACE0, NONE, PA, "R1");
    flags(1'b0, 1'b0, 1'b0, "R1");
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    do_reset();
    sc_pack();
    sc_fill_a();
    sc_swap_b();
    sc_back_a();
    sc_overrun();
    sc_resume();
    sc_midreset();
    summary();
  end
endmodule